// File: doc/BRIEF.md
# Programmable Interrupt Controller Command Unit

This block is the command and state core of one eight-line priority interrupt controller. Eight request lines are edge-detected into a request register. A rotating-priority resolver compares the highest unmasked request with the highest line that is still being serviced. Whenever the request outranks every in-service line, the interrupt output is driven high combinationally.

Software programs the unit through an 8-bit register interface with a 1-bit address. A write to address 0 with bit 4 set starts a short initialization sequence that continues on address 1. Other writes to address 0 are operation commands: end-of-interrupt in several forms, priority rotation, read selection, poll arming and special mask mode. Outside initialization, writes to address 1 load the mask.

An acknowledge strobe returns a vector made of the programmed base and the winning line, and it moves that line into service. A poll read services the winning line in place of the acknowledge cycle.

Top module: `pic_cmd_core`

## Requirements
- R1: After reset the interrupt output is low, an address 0 read returns the request register (0x00), and an address 1 read returns the mask (0x00).
- R2: A rising edge on a request line sets its request bit at the next clock edge, and the interrupt output rises from that edge onwards if the line is unmasked. A line held high does not request again after it has been acknowledged.
- R3: Priority rotates from a base line b: line b ranks highest, then b+1, and so on modulo 8. After reset or initialization b is 0, which gives fixed priority with line 0 highest.
- R4: An address 0 write with bit 4 set clears the mask, in-service and request registers, the priority base, the vector base and all mode flags. The next address 1 write stores bits 7:3 as the vector base. The write after that ends the sequence unless bit 0 of the starting word was 1. In that case a further address 1 write sets auto-EOI from bit 1 and special nesting from bit 4.
- R5: Outside initialization, an address 1 write loads the mask register, which address 1 reads return. A masked request never drives the interrupt output, and the output falls as soon as the mask covers the request.
- R6: An address 0 write with bit 4 = 0, bit 3 = 1 and bit 1 = 1 selects the in-service register (bit 0 = 1) or the request register (bit 0 = 0) for address 0 reads. With bit 1 = 0 the selection is unchanged.
- R7: The acknowledge strobe returns vector = {vector base[7:3], line}. Without auto-EOI it sets the line's in-service bit and clears its request bit. Lines of equal or lower priority are then held off until that service ends.
- R8: An address 0 write with bits 4:3 = 0 and bits 7:5 = 1 (0x20) clears the highest-priority in-service bit. Bits 7:5 = 5 (0xA0) also sets the priority base to that line + 1.
- R9: Bits 7:5 = 3 clears in-service bit [2:0]. Bits 7:5 = 7 does the same and sets the base to [2:0] + 1. Bits 7:5 = 6 only sets the base to [2:0] + 1. Bits 7:5 = 2 has no effect.
- R10: In auto-EOI mode an acknowledge leaves the in-service register unchanged. Command bits 7:5 = 4 (0x80) enables rotation on acknowledge, which sets the base to line + 1. Bits 7:5 = 0 disables it.
- R11: An address 0 write with bit 4 = 0, bit 3 = 1 and bit 2 = 1 arms a poll. The next read at either address returns the winning line index (or 7 if no interrupt is active), clears that line's request and in-service bits, and disarms the poll.
- R12: A command write with bit 6 = 1 sets special mask mode to bit 5 (0x68 on, 0x48 off). In this mode an in-service line that is masked does not block lower-priority requests.
- R13: With special nesting set, in-service line CASCADE_LINE (2) does not block any request, including a new request on line 2 or a lower-priority line.
- R14: An acknowledge with the interrupt output low returns {vector base, 3'd7} and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines, rising-edge sensitive |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (consumes an armed poll) |
| addr | input | 1 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational |
| ack | input | 1 | Interrupt acknowledge strobe |
| int_out | output | 1 | Interrupt request to the processor, combinational |
| vector | output | 8 | Vector for the current acknowledge, combinational |

## Verification
Read data and the vector are combinational, so the bench samples them 1 ns after it raises the strobe, in the same cycle. Register effects of writes, acknowledges, poll reads and request edges appear after exactly one rising edge. Every stimulus task therefore drives at a falling edge and returns at the next falling edge, and only then is the interrupt output or a register read back. A sweep over all eight priority bases and eight request patterns computes the expected winner arithmetically in the bench.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES  = 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int RANK_W = IDX_W + 1;
  localparam int DATA_W = 8;

  typedef logic [LINES-1:0] line_vec_t;
  typedef logic [IDX_W-1:0] line_idx_t;
  typedef logic [RANK_W-1:0] rank_t;

  typedef enum logic [1:0] {
    STEP_IDLE,
    STEP_BASE,
    STEP_TWO,
    STEP_MODE
  } init_step_t;

  typedef struct packed {
    logic read_isr;
    logic poll;
    logic smask;
    logic aeoi;
    logic rot_aeoi;
    logic snest;
    logic need_mode;
  } mode_t;

  localparam logic [2:0] OP_ROT_OFF   = 3'd0;
  localparam logic [2:0] OP_EOI       = 3'd1;
  localparam logic [2:0] OP_NOP       = 3'd2;
  localparam logic [2:0] OP_EOI_LINE  = 3'd3;
  localparam logic [2:0] OP_ROT_ON    = 3'd4;
  localparam logic [2:0] OP_EOI_ROT   = 3'd5;
  localparam logic [2:0] OP_SET_BASE  = 3'd6;
  localparam logic [2:0] OP_EOI_LROT  = 3'd7;

  // rank of the best set bit counted from base b; LINES when vector is empty
  function automatic rank_t find_rank(input line_vec_t v, input line_idx_t b);
    rank_t r;
    r = rank_t'(LINES);
    for (int p = LINES - 1; p >= 0; p--) begin
      if (v[b + line_idx_t'(p)]) r = rank_t'(p);
    end
    return r;
  endfunction
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch
  import pic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t lines,
  input  logic      clr_all,
  input  line_vec_t clr_mask,
  output line_vec_t irr
);
  line_vec_t prev_q, irr_d;
  line_vec_t rise;

  assign rise = lines & ~prev_q;

  always_comb begin
    if (clr_all) irr_d = '0;
    else         irr_d = (irr & ~clr_mask) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr    <= '0;
    end else begin
      prev_q <= lines;
      irr    <= irr_d;
    end
  end
endmodule

// File: rtl/pic_prio_resolver.sv
module pic_prio_resolver
  import pic_pkg::*;
(
  input  line_vec_t req,
  input  line_idx_t base,
  output rank_t     rank,
  output line_idx_t line
);
  always_comb begin
    rank = find_rank(req, base);
    line = base + rank[IDX_W-1:0];
  end
endmodule

// File: rtl/pic_cmd_core.sv
module pic_cmd_core
  import pic_pkg::*;
#(
  parameter int CASCADE_LINE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ack,
  output logic              int_out,
  output logic [DATA_W-1:0] vector
);
  localparam line_vec_t CASC_BIT = line_vec_t'(1) << CASCADE_LINE;
  localparam int        VB_W     = DATA_W - IDX_W;

  line_vec_t        imr_q, imr_d, isr_q, isr_d, irr;
  line_idx_t        prio_q, prio_d;
  logic [VB_W-1:0]  vbase_q, vbase_d;
  mode_t            mode_q, mode_d;
  init_step_t       step_q, step_d;

  line_vec_t req_vec, blk_vec, clr_mask;
  rank_t     req_rank, eoi_rank, blk_rank;
  line_idx_t req_line, eoi_line, sel_line;
  logic      wr0, wr1, is_init, is_sel, is_op;
  logic      take_ack, poll_rd, poll_hit, eoi_v, upd_en;
  logic [2:0] op;
  logic      aeoi_on, init_idle;

  // ---------------- resolvers ----------------
  assign req_vec = irr & ~imr_q;
  assign blk_vec = isr_q & (mode_q.smask ? ~imr_q : '1)
                         & (mode_q.snest ? ~CASC_BIT : '1);

  pic_prio_resolver u_req (.req(req_vec), .base(prio_q), .rank(req_rank), .line(req_line));
  pic_prio_resolver u_eoi (.req(isr_q),   .base(prio_q), .rank(eoi_rank), .line(eoi_line));

  assign blk_rank = find_rank(blk_vec, prio_q);
  assign eoi_v    = (eoi_rank != rank_t'(LINES));
  assign int_out  = (req_rank != rank_t'(LINES)) && (req_rank < blk_rank);

  // ---------------- decode ----------------
  assign wr0      = wr_en && !addr;
  assign wr1      = wr_en && addr;
  assign is_init  = wr0 && wr_data[4];
  assign is_sel   = wr0 && !wr_data[4] && wr_data[3];
  assign is_op    = wr0 && !wr_data[4] && !wr_data[3];
  assign op       = wr_data[7:5];
  assign sel_line = wr_data[IDX_W-1:0];
  assign take_ack = ack && int_out;
  assign poll_rd  = rd_en && mode_q.poll;
  assign poll_hit = poll_rd && int_out;
  assign upd_en   = wr_en || rd_en || ack;
  assign clr_mask = (take_ack || poll_hit) ? (line_vec_t'(1) << req_line) : '0;

  assign aeoi_on   = mode_q.aeoi;
  assign init_idle = (step_q == STEP_IDLE);

  pic_req_latch u_latch (
    .clk(clk), .rst_n(rst_n), .lines(irq_in),
    .clr_all(is_init), .clr_mask(clr_mask), .irr(irr)
  );

  // ---------------- outputs ----------------
  always_comb begin
    if (mode_q.poll)       rd_data = int_out ? DATA_W'(req_line) : DATA_W'(LINES - 1);
    else if (addr)         rd_data = imr_q;
    else if (mode_q.read_isr) rd_data = isr_q;
    else                   rd_data = irr;
  end

  assign vector = {vbase_q, int_out ? req_line : line_idx_t'(LINES - 1)};

  // ---------------- next state ----------------
  always_comb begin
    imr_d   = imr_q;
    isr_d   = isr_q;
    prio_d  = prio_q;
    vbase_d = vbase_q;
    mode_d  = mode_q;
    step_d  = step_q;

    if (take_ack) begin
      if (mode_q.aeoi) begin
        if (mode_q.rot_aeoi) prio_d = req_line + line_idx_t'(1);
      end else begin
        isr_d[req_line] = 1'b1;
      end
    end
    if (poll_hit) isr_d[req_line] = 1'b0;
    if (poll_rd)  mode_d.poll = 1'b0;

    if (is_init) begin
      imr_d            = '0;
      isr_d            = '0;
      prio_d           = '0;
      vbase_d          = '0;
      mode_d           = '0;
      mode_d.need_mode = wr_data[0];
      step_d           = STEP_BASE;
    end else if (is_sel) begin
      if (wr_data[2]) mode_d.poll = 1'b1;
      if (wr_data[1]) mode_d.read_isr = wr_data[0];
      if (wr_data[6]) mode_d.smask = wr_data[5];
    end else if (is_op) begin
      case (op)
        OP_ROT_OFF, OP_ROT_ON: mode_d.rot_aeoi = op[2];
        OP_EOI, OP_EOI_ROT: begin
          if (eoi_v) begin
            isr_d[eoi_line] = 1'b0;
            if (op == OP_EOI_ROT) prio_d = eoi_line + line_idx_t'(1);
          end
        end
        OP_EOI_LINE: isr_d[sel_line] = 1'b0;
        OP_SET_BASE: prio_d = sel_line + line_idx_t'(1);
        OP_EOI_LROT: begin
          isr_d[sel_line] = 1'b0;
          prio_d          = sel_line + line_idx_t'(1);
        end
        default: ;
      endcase
    end else if (wr1) begin
      case (step_q)
        STEP_IDLE: imr_d = wr_data;
        STEP_BASE: begin
          vbase_d = wr_data[DATA_W-1:IDX_W];
          step_d  = STEP_TWO;
        end
        STEP_TWO: step_d = mode_q.need_mode ? STEP_MODE : STEP_IDLE;
        default: begin
          mode_d.snest = wr_data[4];
          mode_d.aeoi  = wr_data[1];
          step_d       = STEP_IDLE;
        end
      endcase
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q   <= '0;
      isr_q   <= '0;
      prio_q  <= '0;
      vbase_q <= '0;
      mode_q  <= '0;
      step_q  <= STEP_IDLE;
    end else if (upd_en) begin
      imr_q   <= imr_d;
      isr_q   <= isr_d;
      prio_q  <= prio_d;
      vbase_q <= vbase_d;
      mode_q  <= mode_d;
      step_q  <= step_d;
    end
  end
endmodule

// File: rtl/pic_cmd_core_chk.sv
module pic_cmd_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] wr_data,
  input logic       ack,
  input logic       int_out,
  input logic [7:0] vector,
  input logic [7:0] imr,
  input logic [7:0] isr,
  input logic [7:0] irr,
  input logic       aeoi_on,
  input logic       init_idle
);
  assert_int_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (!imr[vector[2:0]] && irr[vector[2:0]]));

  assert_init_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wr_data[4]) |=> (imr == 8'h00 && isr == 8'h00 && irr == 8'h00));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && init_idle) |=> (imr == $past(wr_data)));

  assert_ack_in_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !aeoi_on && !wr_en && !rd_en) |=> isr[$past(vector[2:0])]);

  assert_aeoi_keeps_isr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && aeoi_on && !wr_en && !rd_en) |=> $stable(isr));

  assert_spurious_ack_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_out && !wr_en && !rd_en) |=> ($stable(isr) && $stable(imr)));
endmodule

bind pic_cmd_core pic_cmd_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_data(wr_data), .ack(ack), .int_out(int_out), .vector(vector),
  .imr(imr_q), .isr(isr_q), .irr(irr), .aeoi_on(aeoi_on), .init_idle(init_idle)
);

// File: tb/pic_cmd_core_bench.sv
module pic_cmd_core_bench;
  logic       clk, rst_n;
  logic [7:0] irq_in;
  logic       wr_en, rd_en, addr, ack;
  logic [7:0] wr_data;
  logic [7:0] rd_data, vector;
  logic       int_out;
  int         n_chk, n_fail;
  logic [7:0] v;

  pic_cmd_core u_pic_cmd_core (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .ack(ack),
    .int_out(int_out), .vector(vector)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_ack(output logic [7:0] d);
    ack = 1'b1;
    #1 d = vector;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic set_lines(input logic [7:0] l);
    irq_in = l;
    @(negedge clk);
  endtask

  task automatic get_isr(output logic [7:0] d);
    wr(1'b0, 8'h0B);
    rd(1'b0, d);
    wr(1'b0, 8'h0A);
  endtask

  task automatic chk_int(input string tag, input logic exp);
    chk(tag, {7'b0, int_out}, {7'b0, exp});
  endtask

  task automatic init_basic(input logic [7:0] base);
    set_lines(8'h00);
    wr(1'b0, 8'h10);
    wr(1'b0 ^ 1'b1, base);
    wr(1'b1, 8'h00);
  endtask

  function automatic logic [2:0] winner(input logic [7:0] pat, input int b);
    logic [2:0] w;
    w = 3'd0;
    for (int k = 7; k >= 0; k--) begin
      if (pat[(b + k) % 8]) w = 3'((b + k) % 8);
    end
    return w;
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] pats [8];
    pats = '{8'h01, 8'h80, 8'h81, 8'h3C, 8'hA5, 8'hFF, 8'h42, 8'h18};
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; irq_in = '0; wr_en = 0; rd_en = 0; addr = 0; ack = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_int("R1 int", 1'b0);
    rd(1'b0, v); chk("R1 irr", v, 8'h00);
    rd(1'b1, v); chk("R1 imr", v, 8'h00);

    // R5 mask, R2 latch
    wr(1'b1, 8'hFF); rd(1'b1, v); chk("R5 mask read", v, 8'hFF);
    set_lines(8'h08); chk_int("R5 masked", 1'b0);
    rd(1'b0, v); chk("R2 irr set", v, 8'h08);
    wr(1'b1, 8'hF7); chk_int("R5 unmasked", 1'b1);
    wr(1'b1, 8'hFF); chk_int("R5 drop on mask", 1'b0);
    wr(1'b1, 8'h00); chk_int("R5 unmask again", 1'b1);

    // R4 init clears, short sequence
    init_basic(8'h20);
    rd(1'b1, v); chk("R4 mask cleared", v, 8'h00);
    rd(1'b0, v); chk("R4 irr cleared", v, 8'h00);
    chk_int("R4 int low", 1'b0);
    wr(1'b1, 8'h55); rd(1'b1, v); chk("R4 sequence ended", v, 8'h55);
    wr(1'b1, 8'h00);

    // R2 held line does not re-request
    set_lines(8'h08); chk_int("R2 edge", 1'b1);
    do_ack(v); chk("R7 vector line3", v, 8'h23);
    wr(1'b0, 8'h20); chk_int("R2 held no rerequest", 1'b0);
    set_lines(8'h00); set_lines(8'h08); chk_int("R2 new edge", 1'b1);
    do_ack(v); wr(1'b0, 8'h20);

    // R7 nesting, R6 select, R8/R9 EOIs
    set_lines(8'h00); set_lines(8'h10);
    do_ack(v); chk("R7 vector line4", v, 8'h24);
    get_isr(v); chk("R7 isr set", v, 8'h10);
    rd(1'b0, v); chk("R7 irr cleared", v, 8'h00);
    set_lines(8'h50); chk_int("R7 lower held off", 1'b0);
    rd(1'b0, v); chk("R6 irr sel", v, 8'h40);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R6 isr sel", v, 8'h10);
    wr(1'b0, 8'h08); rd(1'b0, v); chk("R6 bit1 clear keeps sel", v, 8'h10);
    wr(1'b0, 8'h0A); rd(1'b0, v); chk("R6 back to irr", v, 8'h40);
    set_lines(8'h52); chk_int("R7 higher nests", 1'b1);
    do_ack(v); chk("R7 vector line1", v, 8'h21);
    get_isr(v); chk("R7 isr two", v, 8'h12);
    wr(1'b0, 8'h20); get_isr(v); chk("R8 eoi highest", v, 8'h10);
    chk_int("R8 still blocked", 1'b0);
    wr(1'b0, 8'h20); chk_int("R8 released", 1'b1);
    do_ack(v); chk("R7 vector line6", v, 8'h26);
    wr(1'b0, 8'hA0); get_isr(v); chk("R8 rotate eoi clears", v, 8'h00);
    set_lines(8'h00); set_lines(8'h81);
    do_ack(v); chk("R8 base 7 winner", v, 8'h27);
    chk_int("R8 line0 below 7", 1'b0);
    wr(1'b0, 8'h67); chk_int("R9 specific eoi", 1'b1);
    wr(1'b0, 8'h40); chk_int("R9 nop int", 1'b1);
    get_isr(v); chk("R9 nop isr", v, 8'h00);
    do_ack(v); chk("R9 line0", v, 8'h20);
    wr(1'b0, 8'hE0); get_isr(v); chk("R9 eoi rotate clears", v, 8'h00);
    wr(1'b0, 8'hC3);
    set_lines(8'h00); set_lines(8'h28);
    do_ack(v); chk("R9 set base 4", v, 8'h25);
    wr(1'b0, 8'h65); chk_int("R9 eoi line5", 1'b1);
    do_ack(v); chk("R9 then line3", v, 8'h23);
    wr(1'b0, 8'h20); chk_int("R8 all served", 1'b0);

    // R4 four-word init, R10 auto-EOI
    set_lines(8'h00);
    wr(1'b0, 8'h11); wr(1'b1, 8'h48); wr(1'b1, 8'h00); wr(1'b1, 8'h02);
    rd(1'b1, v); chk("R4 mode word not mask", v, 8'h00);
    set_lines(8'h20);
    do_ack(v); chk("R4 vector base", v, 8'h4D);
    get_isr(v); chk("R10 isr untouched", v, 8'h00);
    chk_int("R10 int low after ack", 1'b0);
    wr(1'b0, 8'h80);
    set_lines(8'h22);
    do_ack(v); chk("R10 line1", v, 8'h49);
    set_lines(8'h00); set_lines(8'h09);
    do_ack(v); chk("R10 rotated base2", v, 8'h4B);
    do_ack(v); chk("R10 rotated base4", v, 8'h48);
    wr(1'b0, 8'h00);
    set_lines(8'h00); set_lines(8'h20);
    do_ack(v); chk("R10 line5 base1", v, 8'h4D);
    set_lines(8'h00); set_lines(8'h09);
    do_ack(v); chk("R10 rotation off", v, 8'h4B);

    // R11 poll
    init_basic(8'h20);
    set_lines(8'h24);
    wr(1'b0, 8'h0C); rd(1'b0, v); chk("R11 poll line2", v, 8'h02);
    rd(1'b0, v); chk("R11 disarmed", v, 8'h20);
    wr(1'b0, 8'h0C); rd(1'b1, v); chk("R11 poll line5", v, 8'h05);
    wr(1'b0, 8'h0C); rd(1'b0, v); chk("R11 poll empty", v, 8'h07);
    get_isr(v); chk("R11 isr clear", v, 8'h00);
    chk_int("R11 int low", 1'b0);

    // R12 special mask
    init_basic(8'h20);
    set_lines(8'h08);
    do_ack(v); chk("R12 ack3", v, 8'h23);
    set_lines(8'h48); chk_int("R12 blocked", 1'b0);
    wr(1'b1, 8'h08); chk_int("R12 mask only", 1'b0);
    wr(1'b0, 8'h68); chk_int("R12 smm on", 1'b1);
    wr(1'b0, 8'h48); chk_int("R12 smm off", 1'b0);
    wr(1'b1, 8'h00);

    // R13 special nesting
    set_lines(8'h00);
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h00); wr(1'b1, 8'h10);
    set_lines(8'h04);
    do_ack(v); chk("R13 ack2", v, 8'h22);
    set_lines(8'h0C); chk_int("R13 not blocked", 1'b1);
    do_ack(v); chk("R13 ack3", v, 8'h23);
    get_isr(v); chk("R13 isr", v, 8'h0C);

    // R14 spurious ack
    init_basic(8'h20);
    do_ack(v); chk("R14 spurious vector", v, 8'h27);
    get_isr(v); chk("R14 isr", v, 8'h00);
    chk_int("R14 int", 1'b0);

    // R3 sweep over bases and patterns
    for (int b = 0; b < 8; b++) begin
      for (int p = 0; p < 8; p++) begin
        init_basic(8'h40);
        wr(1'b0, 8'hC0 | 8'((b + 7) % 8));
        set_lines(pats[p]);
        chk_int("R2 sweep int", 1'b1);
        do_ack(v); chk("R3 sweep winner", v, 8'h40 | 8'(winner(pats[p], b)));
        get_isr(v); chk("R7 sweep isr", v, 8'h01 << winner(pats[p], b));
      end
    end

    summary();
  end
endmodule